// File: doc/BRIEF.md
# Cascaded Fall-Through Queue Chain

This block is a deep queue made from several shallow first-word-fall-through stages connected in series. Each stage shows its oldest word at its output without a read. Its active-low "has data" line drives the write enable of the next stage directly, and the next stage's active-low "has room" line allows the transfer. A free-running clock therefore carries words along the chain. A word written into an empty chain ripples down to the far end with no read. A free slot made by reading a full chain bubbles back up to the entry stage.

The data word is split into several lanes for width expansion. Each lane is a complete chain with its own handshake. All lanes share the write and read enables. The block reports the lanes' ready lines as composite flags: the logical OR of each lane's active-low output-ready and input-ready lines. Total depth is the number of stages times the depth of one stage.

Top module: `fallchain_top`

## Requirements
- R1: After reset, `outReadyN` is high (no data) and `inReadyN` is low (room available). Both flags are active low.
- R2: A word on `wrData` is accepted on a rising edge only when `wrEnN` and `inReadyN` are both low. A write attempted while `inReadyN` is high is discarded and never appears at the output.
- R3: A read is accepted on a rising edge only when `rdEnN` and `outReadyN` are both low. While `outReadyN` is low, `rdData` shows the oldest word and holds it until that word is read.
- R4: A word written into an empty chain makes `outReadyN` fall just after the rising edge N_STAGES−1 cycles after the accepting edge. No read is needed for this.
- R5: Once the first word has arrived, writing and reading on every cycle keeps `outReadyN` low and moves one word per cycle. Later words add no delay.
- R6: With no reads, the chain accepts exactly N_STAGES×STAGE_DEPTH words, and `inReadyN` is then high.
- R7: When one word is read from a full chain, `inReadyN` falls just after the rising edge N_STAGES−1 cycles after the read edge, as the free slot bubbles up.
- R8: Words leave in the order they were accepted, with none lost and none duplicated, under any pattern of stalls at either end. `outReadyN` is never low while the chain holds no word.
- R9: `outReadyN` is the OR of the lanes' output-ready lines and `inReadyN` is the OR of their input-ready lines. Lane l carries bits [l×LANE_W +: LANE_W] of the word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running transfer clock |
| rstN | input | 1 | Active-low synchronous reset; empties every stage |
| wrEnN | input | 1 | Active-low write request at the chain entry |
| wrData | input | LANES×LANE_W | Word to write, lanes side by side |
| inReadyN | output | 1 | Composite active-low room flag (OR over lanes) |
| rdEnN | input | 1 | Active-low read request at the chain exit |
| rdData | output | LANES×LANE_W | Oldest word, valid while outReadyN is low |
| outReadyN | output | 1 | Composite active-low data flag (OR over lanes) |

## Verification
A single word into an empty chain measures the ripple-down delay edge by edge. A single read from a full chain measures the bubble-up delay the same way, and the two delays are told apart from the one-cycle case. A continuous write-and-read stream shows that only the first word pays the ripple delay. A write-only fill, with further writes pressed against the full entry stage, shows the exact capacity and that rejected words vanish. A long run with random stalls at both ends is compared word by word and lane by lane against a queue model. This catches reordering, loss or duplication that the directed patterns could miss.

// File: rtl/fallchain_pkg.sv
package fallchain_pkg;
  // Per-stage strobes from control to datapath
  typedef struct packed {
    logic push;   // stage takes the word at its input
    logic pop;    // stage releases its head word
  } stageStrobe_t;
endpackage

// File: rtl/fallchain_ctrl.sv
module fallchain_ctrl
  import fallchain_pkg::*;
#(
  parameter int N_STAGES    = 3,
  parameter int STAGE_DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         wrEnN,
  input  logic                         rdEnN,
  output stageStrobe_t [N_STAGES-1:0]  strobe,
  output logic                         chainInReadyN,
  output logic                         chainOutReadyN
);
  localparam int CNT_W = $clog2(STAGE_DEPTH + 1);

  logic [N_STAGES-1:0] stageOrN;   // active low: stage head valid
  logic [N_STAGES-1:0] stageIrN;   // active low: stage has room

  for (genvar k = 0; k < N_STAGES; k++) begin : g_stage
    logic [CNT_W-1:0] cnt;

    assign stageOrN[k] = (cnt == '0);
    assign stageIrN[k] = (cnt == CNT_W'(STAGE_DEPTH));

    // Output-ready of the stage before drives this stage's write directly
    if (k == 0) begin : g_head
      assign strobe[k].push = !wrEnN && !stageIrN[k];
    end else begin : g_link
      assign strobe[k].push = !stageOrN[k-1] && !stageIrN[k];
    end

    if (k == N_STAGES - 1) begin : g_tail
      assign strobe[k].pop = !rdEnN && !stageOrN[k];
    end else begin : g_pass
      assign strobe[k].pop = !stageOrN[k] && !stageIrN[k+1];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cnt <= '0;
      end else begin
        case ({strobe[k].push, strobe[k].pop})
          2'b10:   cnt <= cnt + 1'b1;
          2'b01:   cnt <= cnt - 1'b1;
          default: cnt <= cnt;
        endcase
      end
    end
  end

  assign chainInReadyN  = stageIrN[0];
  assign chainOutReadyN = stageOrN[N_STAGES-1];
endmodule

// File: rtl/fallchain_data.sv
module fallchain_data
  import fallchain_pkg::*;
#(
  parameter int N_STAGES    = 3,
  parameter int STAGE_DEPTH = 4,
  parameter int DATA_W      = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  stageStrobe_t [N_STAGES-1:0]  strobe,
  input  logic [DATA_W-1:0]            wrData,
  output logic [DATA_W-1:0]            rdData
);
  localparam int PTR_W = (STAGE_DEPTH > 1) ? $clog2(STAGE_DEPTH) : 1;

  logic [DATA_W-1:0] headData [N_STAGES];

  function automatic logic [PTR_W-1:0] bumpPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(STAGE_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar k = 0; k < N_STAGES; k++) begin : g_stage
    logic [DATA_W-1:0] mem [STAGE_DEPTH];
    logic [PTR_W-1:0]  wrPtr;
    logic [PTR_W-1:0]  rdPtr;
    logic [DATA_W-1:0] stageIn;

    if (k == 0) begin : g_src_port
      assign stageIn = wrData;
    end else begin : g_src_prev
      assign stageIn = headData[k-1];
    end

    always_ff @(posedge clk) begin
      if (strobe[k].push) mem[wrPtr] <= stageIn;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        wrPtr <= '0;
        rdPtr <= '0;
      end else begin
        if (strobe[k].push) wrPtr <= bumpPtr(wrPtr);
        if (strobe[k].pop)  rdPtr <= bumpPtr(rdPtr);
      end
    end

    // Fall-through: head word is visible without a read
    assign headData[k] = mem[rdPtr];
  end

  assign rdData = headData[N_STAGES-1];
endmodule

// File: rtl/fallchain_top.sv
module fallchain_top
  import fallchain_pkg::*;
#(
  parameter int LANES       = 2,
  parameter int LANE_W      = 8,
  parameter int N_STAGES    = 3,
  parameter int STAGE_DEPTH = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wrEnN,
  input  logic [LANES*LANE_W-1:0]   wrData,
  output logic                      inReadyN,
  input  logic                      rdEnN,
  output logic [LANES*LANE_W-1:0]   rdData,
  output logic                      outReadyN
);
  logic [LANES-1:0] laneIrN;
  logic [LANES-1:0] laneOrN;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    stageStrobe_t [N_STAGES-1:0] strobe;

    fallchain_ctrl #(
      .N_STAGES(N_STAGES), .STAGE_DEPTH(STAGE_DEPTH)
    ) u_ctrl (
      .clk(clk), .rstN(rstN), .wrEnN(wrEnN), .rdEnN(rdEnN),
      .strobe(strobe), .chainInReadyN(laneIrN[l]), .chainOutReadyN(laneOrN[l])
    );

    fallchain_data #(
      .N_STAGES(N_STAGES), .STAGE_DEPTH(STAGE_DEPTH), .DATA_W(LANE_W)
    ) u_data (
      .clk(clk), .rstN(rstN), .strobe(strobe),
      .wrData(wrData[l*LANE_W +: LANE_W]), .rdData(rdData[l*LANE_W +: LANE_W])
    );
  end

  // Composite flags: any lane not ready keeps the whole word not ready
  assign inReadyN  = |laneIrN;
  assign outReadyN = |laneOrN;
endmodule

// File: rtl/fallchain_chk.sv
module fallchain_chk #(
  parameter int LANES       = 2,
  parameter int DATA_W      = 16,
  parameter int N_STAGES    = 3,
  parameter int STAGE_DEPTH = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEnN,
  input logic              rdEnN,
  input logic              inReadyN,
  input logic              outReadyN,
  input logic [DATA_W-1:0] rdData,
  input logic [LANES-1:0]  laneIrN,
  input logic [LANES-1:0]  laneOrN
);
  localparam int TOTAL = N_STAGES * STAGE_DEPTH;
  localparam int OCC_W = $clog2(TOTAL + 1) + 1;
  localparam int AGE_W = $clog2(N_STAGES + 1) + 1;

  logic [OCC_W-1:0] occ;
  logic [OCC_W-1:0] occNext;
  logic [AGE_W-1:0] age;
  logic wrAcc, rdAcc;

  assign wrAcc   = !wrEnN && !inReadyN;
  assign rdAcc   = !rdEnN && !outReadyN;
  assign occNext = occ + OCC_W'(wrAcc) - OCC_W'(rdAcc);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      occ <= '0;
      age <= '0;
    end else begin
      occ <= occNext;
      if (occNext == '0)                 age <= '0;
      else if (age < AGE_W'(N_STAGES))   age <= age + 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    occ <= OCC_W'(TOTAL)); // R6
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (occ == OCC_W'(TOTAL)) |-> inReadyN); // R6
  AST_READY_HAS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    !outReadyN |-> (occ != '0)); // R8
  AST_FIRST_WORD_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    !outReadyN |-> (age == AGE_W'(N_STAGES))); // R4
  AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!outReadyN && rdEnN) |=> (!outReadyN && $stable(rdData))); // R3
  AST_LANES_LOCKSTEP: assert property (@(posedge clk) disable iff (!rstN)
    ((laneOrN == '0 || laneOrN == '1) && (laneIrN == '0 || laneIrN == '1))); // R9
endmodule

bind fallchain_top fallchain_chk #(
  .LANES(LANES), .DATA_W(LANES*LANE_W), .N_STAGES(N_STAGES), .STAGE_DEPTH(STAGE_DEPTH)
) u_chk (
  .clk(clk), .rstN(rstN), .wrEnN(wrEnN), .rdEnN(rdEnN),
  .inReadyN(inReadyN), .outReadyN(outReadyN), .rdData(rdData),
  .laneIrN(laneIrN), .laneOrN(laneOrN)
);

// File: tb/sim_fallchain_top.sv
`timescale 1ns/1ps
module sim_fallchain_top;
  localparam int LANES = 2, LANE_W = 8, N_STAGES = 3, STAGE_DEPTH = 4;
  localparam int DW = LANES * LANE_W;
  localparam int TOTAL = N_STAGES * STAGE_DEPTH;

  logic clk = 1'b0, rstN = 1'b0, wrEnN = 1'b1, rdEnN = 1'b1;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic inReadyN, outReadyN;

  int tests = 0, fails = 0;
  logic [DW-1:0] q[$];

  always #2 clk = ~clk;

  fallchain_top #(.LANES(LANES), .LANE_W(LANE_W), .N_STAGES(N_STAGES),
    .STAGE_DEPTH(STAGE_DEPTH)) u0 (
    .clk(clk), .rstN(rstN), .wrEnN(wrEnN), .wrData(wrData), .inReadyN(inReadyN),
    .rdEnN(rdEnN), .rdData(rdData), .outReadyN(outReadyN));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  // Compare outputs with the queue model (called at a negedge)
  task automatic compare();
    if (!outReadyN) begin
      chk(q.size() > 0, "R8 data flag with empty model", q.size(), 1);
      if (q.size() > 0)
        for (int l = 0; l < LANES; l++)
          chk(rdData[l*LANE_W +: LANE_W] == q[0][l*LANE_W +: LANE_W],
              $sformatf("R9 lane %0d data", l),
              rdData[l*LANE_W +: LANE_W], q[0][l*LANE_W +: LANE_W]);
    end
    if (q.size() == TOTAL) chk(inReadyN == 1'b1, "R6 full chain room flag", inReadyN, 1);
  endtask

  // One cycle: compare, drive, update model, advance to next negedge
  task automatic cyc(input logic w, input logic [DW-1:0] d, input logic r,
                     output bit wAcc, output bit rAcc);
    compare();
    wrEnN = w; wrData = d; rdEnN = r;
    wAcc = !w && !inReadyN;
    rAcc = !r && !outReadyN;
    if (wAcc) q.push_back(d);
    if (rAcc) void'(q.pop_front());
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "R8 watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    bit wa, ra;
    int cnt;
    bit started;
    logic [DW-1:0] firstWord;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    chk(outReadyN == 1'b1, "R1 outReadyN after reset", outReadyN, 1);
    chk(inReadyN == 1'b0, "R1 inReadyN after reset", inReadyN, 0);

    // R4 ripple-down of one word
    cyc(1'b0, 16'hA55A, 1'b1, wa, ra);
    chk(wa, "R2 write accepted into empty chain", wa, 1);
    for (int k = 0; k < N_STAGES; k++) begin
      chk(outReadyN == ((k < N_STAGES - 1) ? 1'b1 : 1'b0),
          $sformatf("R4 outReadyN %0d edges after write", k), outReadyN, (k < N_STAGES - 1));
      if (k < N_STAGES - 1) cyc(1'b1, '0, 1'b1, wa, ra);
    end
    chk(rdData == 16'hA55A, "R3 head word shown without read", rdData, 16'hA55A);
    cyc(1'b1, '0, 1'b0, wa, ra);
    chk(ra, "R3 read accepted", ra, 1);

    // R5 streaming: no added delay after the first word
    cnt = 0; started = 0;
    for (int i = 0; i < 40; i++) begin
      if (started && outReadyN) cnt++;
      if (!outReadyN) started = 1;
      cyc(1'b0, DW'(16'h0100 + i * 16'h0203), started ? 1'b0 : 1'b1, wa, ra);
    end
    chk(cnt == 0, "R5 output gaps while streaming", cnt, 0);
    for (int i = 0; i < TOTAL + 2 * N_STAGES; i++) cyc(1'b1, '0, 1'b0, wa, ra);
    chk(q.size() == 0 && outReadyN, "R8 chain drained after stream", q.size(), 0);

    // R6 fill with no reads, keep pressing writes against the full entry
    cnt = 0;
    for (int i = 0; i < TOTAL + 4 * N_STAGES; i++) begin
      cyc(1'b0, DW'(16'h3000 + i * 16'h0111), 1'b1, wa, ra);
      if (wa) cnt++;
    end
    chk(cnt == TOTAL, "R6 words accepted before full", cnt, TOTAL);
    chk(inReadyN == 1'b1, "R6 room flag high when full", inReadyN, 1);
    firstWord = DW'(16'h3000);
    chk(rdData == firstWord, "R3 oldest word held while full", rdData, firstWord);

    // R7 bubble-up of one free slot
    cyc(1'b1, '0, 1'b0, wa, ra);
    for (int k = 0; k < N_STAGES; k++) begin
      chk(inReadyN == ((k < N_STAGES - 1) ? 1'b1 : 1'b0),
          $sformatf("R7 inReadyN %0d edges after read", k), inReadyN, (k < N_STAGES - 1));
      if (k < N_STAGES - 1) cyc(1'b1, '0, 1'b1, wa, ra);
    end

    // R2 drain: rejected writes never appear
    cnt = 1;
    for (int i = 0; i < TOTAL + 2 * N_STAGES; i++) begin
      cyc(1'b1, '0, 1'b0, wa, ra);
      if (ra) cnt++;
    end
    chk(cnt == TOTAL, "R2 words read after overfilled writes", cnt, TOTAL);

    // R8 random stalls at both ends
    for (int i = 0; i < 3000; i++)
      cyc(($urandom_range(0, 2) == 0), DW'($urandom), ($urandom_range(0, 2) == 0), wa, ra);
    for (int i = 0; i < TOTAL + 2 * N_STAGES; i++) cyc(1'b1, '0, 1'b0, wa, ra);
    chk(q.size() == 0, "R8 model empty after random run", q.size(), 0);
    chk(outReadyN == 1'b1, "R8 no extra words after random run", outReadyN, 1);

    summary();
    $finish;
  end
endmodule